// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block recovers asynchronous serial characters from a single receive line. A one-cycle tick that runs at sixteen times the bit rate comes in from outside. The receiver confirms each start bit at its middle and then samples every later bit at its centre. It accepts characters of 5 to 9 data bits with optional even or odd parity. Each received character goes into a one-entry holding buffer, which the consumer empties with a read strobe.

Three sticky error indications report problems: a bad stop bit, a parity mismatch, and a character lost because the buffer was still full. Dropping the enable returns the receiver to idle, empties the buffer and clears all three flags. A separate clear strobe empties only the buffer. There is a start-of-character event output. A wake request can also be raised from either or both of two events: a confirmed start bit and a completed character. Each event has its own enable.

Top module: `uart_rx_core`

## Requirements
- R1: The character size code `size_i` selects the number of data bits: 0 gives 8, 1 gives 9, and 5, 6 and 7 give 5, 6 and 7. The unused codes 2 to 4 are treated as 8. Data arrives least significant bit first. `data_o` holds it right-aligned, with the unused upper bits at zero.
- R2: A low level seen on a tick while idle starts a start-bit check. If `rxd_i` is high on the 8th tick after that one, the receiver goes back to idle with no start event and no character.
- R3: `rxs_o` pulses high for exactly one clock when a start bit is confirmed.
- R4: When `par_en_i` is 1, a parity bit follows the data. The XOR of the data bits and the parity bit must equal `par_odd_i` (0 = even, 1 = odd). A mismatch sets `perr_o`, which stays set until the receiver is disabled.
- R5: A low level at the sample of the first stop bit sets `ferr_o`, which is sticky. The character is still placed in the buffer.
- R6: `rxc_o` is high while the buffer holds an unread character. A one-clock `rd_i` pulse empties it.
- R7: If a character completes while the buffer is full and no read or clear comes in the same clock, `ovf_o` is set. The new character is discarded and `data_o` keeps the old one.
- R8: A `clr_i` pulse empties the buffer and leaves `ferr_o`, `perr_o` and `ovf_o` unchanged.
- R9: While `en_i` is 0, the receiver stays idle, the buffer is empty, all three error flags are 0, and incoming characters are ignored.
- R10: When `sfd_en_i` is 1, `wake_o` pulses for one clock after a start event if `ie_rxs_i` is 1, and after a completion event if `ie_rxc_i` is 1. With both enables at 0, or with `sfd_en_i` at 0, it never pulses.
- R11: When `par_en_i` is 0, no parity bit is expected and `perr_o` is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| rxd_i | input | 1 | Serial receive line, idle high |
| en_i | input | 1 | Receiver enable |
| size_i | input | 3 | Character size code |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 0 even, 1 odd parity |
| sfd_en_i | input | 1 | Start-of-frame wake enable |
| ie_rxs_i | input | 1 | Wake on start event |
| ie_rxc_i | input | 1 | Wake on completion event |
| rd_i | input | 1 | Buffer read strobe |
| clr_i | input | 1 | Buffer clear strobe |
| data_o | output | 9 | Received character |
| rxc_o | output | 1 | Buffer holds unread character |
| rxs_o | output | 1 | Start-bit confirmed pulse |
| ferr_o | output | 1 | Frame error, sticky |
| perr_o | output | 1 | Parity error, sticky |
| ovf_o | output | 1 | Overflow, sticky |
| wake_o | output | 1 | Wake request pulse |

## Verification
The hardest state to reach is a completion that arrives while an unread character sits in the buffer. Only then can the lost-character flag rise, and the held data must survive it. The stimulus gets there by sending two whole characters back to back with no read in between. It then clears the buffer and checks that the flag outlives the clear and that the next character loads normally. A short low glitch on the line exercises the start-bit check that fails at the middle of the bit. A stop bit held low exercises the frame error, and it also triggers a second false start that must end without a confirmed start.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_W = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  function automatic logic [3:0] size_bits(input logic [2:0] code);
    case (code)
      3'd1:    return 4'd9;
      3'd5:    return 4'd5;
      3'd6:    return 4'd6;
      3'd7:    return 4'd7;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [2:0]        size_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              start_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ferr_o,
  output logic              perr_o
);
  localparam int unsigned CW = $clog2(OVS);
  localparam logic [CW-1:0] CNT_MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [3:0]        idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              acc_q;
  logic [3:0]        nbits;

  assign nbits = size_bits(size_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      start_o <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
      ferr_o  <= 1'b0;
      perr_o  <= 1'b0;
    end else begin
      start_o <= 1'b0;
      done_o  <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        case (state_q)
          ST_IDLE: if (!rxd_i) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
          ST_START: begin
            if (cnt_q == CNT_MID) begin
              // start confirmed only if still low at mid-bit
              if (!rxd_i) begin
                state_q <= ST_DATA;
                cnt_q   <= '0;
                idx_q   <= '0;
                sh_q    <= '0;
                acc_q   <= 1'b0;
                start_o <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q       <= '0;
              sh_q[idx_q] <= rxd_i;
              acc_q       <= acc_q ^ rxd_i;
              if (idx_q == nbits - 4'd1) state_q <= par_en_i ? ST_PAR : ST_STOP;
              else                       idx_q   <= idx_q + 4'd1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q   <= '0;
              acc_q   <= acc_q ^ rxd_i;
              state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q   <= '0;
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
              data_o  <= sh_q;
              ferr_o  <= ~rxd_i;
              perr_o  <= par_en_i & (acc_q != par_odd_i);
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_hold_buf.sv
module rx_hold_buf
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] fdata_i,
  input  logic              fferr_i,
  input  logic              fperr_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ferr_o,
  output logic              perr_o,
  output logic              ovf_o
);
  logic drain;
  assign drain = rd_i | clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      ferr_o <= 1'b0;
      perr_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else if (!en_i) begin
      data_o <= '0;
      full_o <= 1'b0;
      ferr_o <= 1'b0;
      perr_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      if (drain) full_o <= 1'b0;
      if (done_i) begin
        if (full_o && !drain) begin
          ovf_o <= 1'b1;
        end else begin
          data_o <= fdata_i;
          full_o <= 1'b1;
          ferr_o <= ferr_o | fferr_i;
          perr_o <= perr_o | fperr_i;
        end
      end
    end
  end
endmodule

// File: rtl/rx_wake_gen.sv
module rx_wake_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sfd_en_i,
  input  logic ie_rxs_i,
  input  logic ie_rxc_i,
  input  logic start_i,
  input  logic done_i,
  output logic wake_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_o <= 1'b0;
    else         wake_o <= sfd_en_i & ((ie_rxs_i & start_i) | (ie_rxc_i & done_i));
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              en_i,
  input  logic [2:0]        size_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              sfd_en_i,
  input  logic              ie_rxs_i,
  input  logic              ie_rxc_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rxc_o,
  output logic              rxs_o,
  output logic              ferr_o,
  output logic              perr_o,
  output logic              ovf_o,
  output logic              wake_o
);
  logic              frame_start;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              frame_ferr;
  logic              frame_perr;

  rx_frame_fsm #(.OVS(OVS)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .tick_i    (tick_i),
    .rxd_i     (rxd_i),
    .size_i    (size_i),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .start_o   (frame_start),
    .done_o    (frame_done),
    .data_o    (frame_data),
    .ferr_o    (frame_ferr),
    .perr_o    (frame_perr)
  );

  rx_hold_buf i_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .done_i  (frame_done),
    .fdata_i (frame_data),
    .fferr_i (frame_ferr),
    .fperr_i (frame_perr),
    .rd_i    (rd_i),
    .clr_i   (clr_i),
    .data_o  (data_o),
    .full_o  (rxc_o),
    .ferr_o  (ferr_o),
    .perr_o  (perr_o),
    .ovf_o   (ovf_o)
  );

  rx_wake_gen i_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sfd_en_i (sfd_en_i),
    .ie_rxs_i (ie_rxs_i),
    .ie_rxc_i (ie_rxc_i),
    .start_i  (frame_start),
    .done_i   (frame_done),
    .wake_o   (wake_o)
  );

  assign rxs_o = frame_start;
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk
  import uart_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              rd_i,
  input logic              clr_i,
  input logic              par_en_i,
  input logic              sfd_en_i,
  input logic              ie_rxs_i,
  input logic              ie_rxc_i,
  input logic              done_i,
  input logic [DATA_W-1:0] data_i,
  input logic              rxc_i,
  input logic              rxs_i,
  input logic              ferr_i,
  input logic              perr_i,
  input logic              ovf_i,
  input logic              wake_i
);
  a_r9_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!rxc_i && !ferr_i && !perr_i && !ovf_i));

  a_r3_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxs_i |=> !rxs_i);

  a_r6_read_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rd_i && !done_i) |=> !rxc_i);

  a_r7_ovf_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rxc_i && done_i && !rd_i && !clr_i) |=> (ovf_i && $stable(data_i)));

  a_r8_clear_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_i && !done_i) |=> (!rxc_i && $stable(ferr_i) && $stable(perr_i) && $stable(ovf_i)));

  a_r10_no_wake_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sfd_en_i || (!ie_rxs_i && !ie_rxc_i)) |=> !wake_i);

  a_r10_wake_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfd_en_i && ie_rxs_i && rxs_i) |=> wake_i);

  a_r11_no_perr_without_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !par_en_i && !perr_i) |=> !perr_i);
endmodule

bind uart_rx_core uart_rx_core_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .rd_i     (rd_i),
  .clr_i    (clr_i),
  .par_en_i (par_en_i),
  .sfd_en_i (sfd_en_i),
  .ie_rxs_i (ie_rxs_i),
  .ie_rxc_i (ie_rxc_i),
  .done_i   (frame_done),
  .data_i   (data_o),
  .rxc_i    (rxc_o),
  .rxs_i    (rxs_o),
  .ferr_i   (ferr_o),
  .perr_i   (perr_o),
  .ovf_i    (ovf_o),
  .wake_i   (wake_o)
);

// File: tb/test_uart_rx_core.sv
`timescale 1ns/1ps
module test_uart_rx_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic       en = 1'b0;
  logic [2:0] size = 3'd0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       sfd_en = 1'b0;
  logic       ie_rxs = 1'b0;
  logic       ie_rxc = 1'b0;
  logic       rd = 1'b0;
  logic       clr = 1'b0;
  logic [8:0] data;
  logic       rxc, rxs, ferr, perr, ovf, wake;

  int checks = 0;
  int errors = 0;
  int rxs_cnt = 0;
  int wake_cnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  uart_rx_core i_uart_rx_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd), .en_i(en),
    .size_i(size), .par_en_i(par_en), .par_odd_i(par_odd), .sfd_en_i(sfd_en),
    .ie_rxs_i(ie_rxs), .ie_rxc_i(ie_rxc), .rd_i(rd), .clr_i(clr),
    .data_o(data), .rxc_o(rxc), .rxs_o(rxs), .ferr_o(ferr), .perr_o(perr),
    .ovf_o(ovf), .wake_o(wake)
  );

  always @(negedge clk) begin
    if (rxs)  rxs_cnt++;
    if (wake) wake_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_bit(input bit b);
    rxd = b;
    repeat (32) @(negedge clk);
  endtask

  task automatic send_frame(input int n, input int d, input int pm, input bit flip, input bit stopv);
    bit p;
    drive_bit(1'b0);
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      drive_bit(d[i]);
      p ^= d[i];
    end
    if (pm != 0) drive_bit(p ^ (pm == 2) ^ flip);
    drive_bit(stopv);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic pulse_rd();
    rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
  endtask

  task automatic recycle_en();
    en = 1'b0; @(negedge clk); en = 1'b1; @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic int size_of(input int code);
    case (code)
      1: return 9;
      5: return 5;
      6: return 6;
      7: return 7;
      default: return 8;
    endcase
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    int codes[6] = '{5, 6, 7, 0, 1, 3};
    int r0, w0, n, d, exp_w;
    repeat (3) @(negedge clk);
    chk(rxc == 0 && ferr == 0 && perr == 0 && ovf == 0 && rxs == 0 && wake == 0,
        "reset", {rxc, ferr, perr, ovf, rxs, wake}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);

    // R1 R4 R6 R11: sweep sizes, parity modes and data patterns
    foreach (codes[ci]) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int k = 0; k < 5; k++) begin
          size = 3'(codes[ci]);
          n = size_of(codes[ci]);
          par_en = (pm != 0);
          par_odd = (pm == 2);
          d = (k == 0) ? 0 : (k == 1) ? ((1 << n) - 1) : ((k * 173 + 91) & ((1 << n) - 1));
          recycle_en();
          r0 = rxs_cnt;
          send_frame(n, d, pm, 1'b0, 1'b1);
          chk(rxc == 1, "R6 rxc set", rxc, 1);
          chk(data == 9'(d), "R1 data", data, d);
          chk(perr == 0 && ferr == 0, "R11 R4 clean flags", {perr, ferr}, 0);
          chk(rxs_cnt - r0 == 1, "R3 one start pulse", rxs_cnt - r0, 1);
          pulse_rd();
          chk(rxc == 0, "R6 read empties", rxc, 0);
        end
      end
    end

    // R4: corrupted parity in both modes
    size = 3'd0;
    for (int pm = 1; pm < 3; pm++) begin
      par_en = 1'b1;
      par_odd = (pm == 2);
      recycle_en();
      send_frame(8, 8'h5A, pm, 1'b1, 1'b1);
      chk(perr == 1, "R4 parity error", perr, 1);
      pulse_rd();
      send_frame(8, 8'h33, pm, 1'b0, 1'b1);
      chk(perr == 1 && data == 9'h33, "R4 perr sticky", perr, 1);
      pulse_rd();
    end

    // R5: stop bit low
    par_en = 1'b0;
    recycle_en();
    r0 = rxs_cnt;
    send_frame(8, 8'hC3, 0, 1'b0, 1'b0);
    chk(ferr == 1, "R5 frame error", ferr, 1);
    chk(rxc == 1 && data == 9'hC3, "R5 data loaded", data, 'hC3);
    chk(rxs_cnt - r0 == 1, "R2 no start from stop tail", rxs_cnt - r0, 1);
    pulse_rd();

    // R9: disable clears flags, then ignores traffic
    en = 1'b0;
    @(negedge clk);
    chk(ferr == 0 && rxc == 0, "R9 disable clears", ferr, 0);
    send_frame(8, 8'h11, 0, 1'b0, 1'b1);
    chk(rxc == 0, "R9 ignored while disabled", rxc, 0);
    en = 1'b1;
    @(negedge clk);

    // R2: short glitch
    r0 = rxs_cnt;
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    chk(rxs_cnt == r0, "R2 glitch no start", rxs_cnt - r0, 0);
    chk(rxc == 0, "R2 glitch no frame", rxc, 0);

    // R7 R8: overflow then clear
    send_frame(8, 8'hA1, 0, 1'b0, 1'b1);
    send_frame(8, 8'h4E, 0, 1'b0, 1'b1);
    chk(ovf == 1, "R7 overflow", ovf, 1);
    chk(data == 9'hA1 && rxc == 1, "R7 old data kept", data, 'hA1);
    pulse_clr();
    chk(rxc == 0, "R8 clear empties", rxc, 0);
    chk(ovf == 1, "R8 flags kept", ovf, 1);
    send_frame(8, 8'h77, 0, 1'b0, 1'b1);
    chk(data == 9'h77 && rxc == 1, "R8 reload after clear", data, 'h77);
    en = 1'b0;
    @(negedge clk);
    chk(ovf == 0 && rxc == 0, "R9 disable clears ovf", ovf, 0);
    en = 1'b1;
    @(negedge clk);

    // R10: wake gating
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 4; m++) begin
        sfd_en = s[0];
        ie_rxs = m[0];
        ie_rxc = m[1];
        w0 = wake_cnt;
        send_frame(8, 8'h3C, 0, 1'b0, 1'b1);
        pulse_rd();
        exp_w = s * (m[0] + m[1]);
        chk(wake_cnt - w0 == exp_w, "R10 wake count", wake_cnt - w0, exp_w);
      end
    end

    summary();
  end
endmodule